// File: doc/BRIEF.md
# Two-Level Hardware Loop Controller

This block runs two nested zero-overhead loops for a packet-based instruction fetch unit. Each level keeps a start address and an iteration count. A setup command fills one level with a start address, formed from the PC of the setup packet plus an offset, and with an iteration count. Loops are closed by markers carried on the packet, not by branch instructions. The inner-level marker travels with the first word of a packet and the outer-level marker with the second word. The decoder passes both markers in on the packet-end strobe.

On every packet end the controller decides in the same cycle whether fetch must jump back to a stored start address, and it steps the matching count down. A packet may close both levels at once. While the inner loop still has iterations left, only the inner loop is handled. Once the inner loop is finished, the outer loop is judged in that same cycle. A taken explicit branch in the closing packet takes priority over all loop handling.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset both counts and both start addresses are zero and no redirect is requested.
- R2: A setup with level select 0 (inner) or 1 (outer) loads that level's count and sets its start address to (pc_in + setup_offset) with the low ALIGN bits (default 2) cleared. The new count is visible on the count output one cycle later.
- R3: At a packet end flagged inner with inner count above 1, redir_valid is high in the same cycle, redir_target equals the inner start address, and the inner count then drops by one.
- R4: At a packet end flagged inner with inner count equal to 1, no redirect is requested and the inner count becomes 0.
- R5: At a packet end for a level whose count is 0, no redirect comes from that level and the count stays 0 without wrapping.
- R6: At a packet end flagged only outer, the outer level behaves as in R3, R4 and R5 using its own count and start address.
- R7: When both flags are set and the inner count is above 1, only the inner loop is serviced: the target is the inner start and the outer count is unchanged.
- R8: When both flags are set and the inner count is 1 or 0, the inner level is finished as in R4 and R5, and the outer level is evaluated in the same cycle as in R6.
- R9: A taken branch on a packet end suppresses any redirect and leaves both counts unchanged.
- R10: Without the packet-end strobe, the loop-end flags have no effect: there is no redirect and no count change.
- R11: A setup to a level in the same cycle as a packet end wins over that level's decrement. The other level is still serviced normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_valid | input | 1 | Loop setup command strobe |
| setup_level | input | 1 | 0 selects the inner level, 1 the outer level |
| setup_offset | input | AW | Start-address offset added to pc_in |
| setup_count | input | CW | Iteration count to load |
| pc_in | input | AW | PC of the current packet |
| pkt_end | input | 1 | A packet completes this cycle |
| end_inner | input | 1 | Inner loop-end marker (first word of the packet) |
| end_outer | input | 1 | Outer loop-end marker (second word of the packet) |
| branch_taken | input | 1 | An explicit branch in the packet is taken |
| redir_valid | output | 1 | Redirect fetch this cycle |
| redir_target | output | AW | Redirect address |
| count_inner | output | CW | Current inner iteration count |
| count_outer | output | CW | Current outer iteration count |

## Verification
The assertions assume that the loop-end flags and branch_taken matter only while pkt_end is high. They also assume that any count change not caused by a setup comes only from a qualified packet end. Properties about held counts are therefore gated on setup_valid being low. Random stimulus draws small counts (0 to 4) so that the finish and zero cases come up often. It mixes flags with and without the strobe, and it sends setups both alone and in the same cycle as packet ends. A reference model in the bench follows the same inputs.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
   typedef enum logic {
      LVL_INNER = 1'b0,
      LVL_OUTER = 1'b1
   } loop_lvl_e;

   localparam int NUM_LEVELS = 2;
endpackage

// File: rtl/hwloop_level.sv
module hwloop_level #(
   parameter int AW = 32,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_start,
   input  logic [CW-1:0] wr_count,
   input  logic          end_hit,
   output logic [AW-1:0] start_q,
   output logic [CW-1:0] count_q,
   output logic          more
);
   localparam logic [CW-1:0] ONE = CW'(1);

   // more than one pass left: a loop end jumps back
   assign more = count_q > ONE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         count_q <= '0;
      end else if (wr_en) begin
         start_q <= wr_start;
         count_q <= wr_count;
      end else if (end_hit && count_q != '0) begin
         count_q <= count_q - ONE;
      end
   end
endmodule

// File: rtl/hwloop_resolve.sv
module hwloop_resolve #(
   parameter int AW = 32
) (
   input  logic          pkt_end,
   input  logic          end_inner,
   input  logic          end_outer,
   input  logic          branch_taken,
   input  logic          more_inner,
   input  logic          more_outer,
   input  logic [AW-1:0] start_inner,
   input  logic [AW-1:0] start_outer,
   output logic          hit_inner,
   output logic          hit_outer,
   output logic          redir_valid,
   output logic [AW-1:0] redir_target
);
   logic qual;
   logic loop_inner;
   logic loop_outer;

   assign qual       = pkt_end && !branch_taken;
   assign hit_inner  = qual && end_inner;
   assign loop_inner = hit_inner && more_inner;
   // the outer level is looked at only once the inner level lets go
   assign hit_outer  = qual && end_outer && !loop_inner;
   assign loop_outer = hit_outer && more_outer;

   always_comb begin
      redir_valid  = loop_inner || loop_outer;
      redir_target = loop_inner ? start_inner : start_outer;
   end
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
   import hwloop_pkg::*;
#(
   parameter int AW    = 32,
   parameter int CW    = 16,
   parameter int ALIGN = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          setup_valid,
   input  logic          setup_level,
   input  logic [AW-1:0] setup_offset,
   input  logic [CW-1:0] setup_count,
   input  logic [AW-1:0] pc_in,
   input  logic          pkt_end,
   input  logic          end_inner,
   input  logic          end_outer,
   input  logic          branch_taken,
   output logic          redir_valid,
   output logic [AW-1:0] redir_target,
   output logic [CW-1:0] count_inner,
   output logic [CW-1:0] count_outer
);
   localparam logic [AW-1:0] ALIGN_MASK = ~((AW'(1) << ALIGN) - AW'(1));

   if (AW < 8 || AW > 64) begin : g_bad_aw
      $error("hwloop_ctrl: AW out of range");
   end
   if (CW < 2) begin : g_bad_cw
      $error("hwloop_ctrl: CW must be at least 2");
   end
   if (ALIGN < 0 || ALIGN >= AW) begin : g_bad_align
      $error("hwloop_ctrl: ALIGN out of range");
   end

   logic [AW-1:0] setup_addr;
   logic [AW-1:0] sum_addr;
   logic [NUM_LEVELS-1:0]          hit;
   logic [NUM_LEVELS-1:0]          more;
   logic [NUM_LEVELS-1:0][AW-1:0]  start;
   logic [NUM_LEVELS-1:0][CW-1:0]  count;

   assign sum_addr = pc_in + setup_offset;

   if (ALIGN == 0) begin : g_noalign
      assign setup_addr = sum_addr;
   end else begin : g_align
      assign setup_addr = sum_addr & ALIGN_MASK;
   end

   for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
      logic wr;
      assign wr = setup_valid && (loop_lvl_e'(setup_level) == loop_lvl_e'(g));
      hwloop_level #(.AW(AW), .CW(CW)) i_level (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr),
         .wr_start (setup_addr),
         .wr_count (setup_count),
         .end_hit  (hit[g]),
         .start_q  (start[g]),
         .count_q  (count[g]),
         .more     (more[g])
      );
   end

   hwloop_resolve #(.AW(AW)) i_resolve (
      .pkt_end      (pkt_end),
      .end_inner    (end_inner),
      .end_outer    (end_outer),
      .branch_taken (branch_taken),
      .more_inner   (more[0]),
      .more_outer   (more[1]),
      .start_inner  (start[0]),
      .start_outer  (start[1]),
      .hit_inner    (hit[0]),
      .hit_outer    (hit[1]),
      .redir_valid  (redir_valid),
      .redir_target (redir_target)
   );

   assign count_inner = count[0];
   assign count_outer = count[1];
endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          setup_valid,
   input logic          pkt_end,
   input logic          end_inner,
   input logic          end_outer,
   input logic          branch_taken,
   input logic          redir_valid,
   input logic [CW-1:0] count_inner,
   input logic [CW-1:0] count_outer
);
   AST_BRANCH_NO_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_end && branch_taken) |-> !redir_valid); // R9

   AST_BRANCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_end && branch_taken && !setup_valid) |=> ($stable(count_inner) && $stable(count_outer))); // R9

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!pkt_end && !setup_valid) |=> ($stable(count_inner) && $stable(count_outer))); // R10

   AST_REDIR_NEEDS_END: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> (pkt_end && (end_inner || end_outer))); // R10

   AST_ZERO_NO_WRAP_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (count_inner == '0 && !setup_valid) |=> count_inner == '0); // R5

   AST_ZERO_NO_WRAP_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (count_outer == '0 && !setup_valid) |=> count_outer == '0); // R5

   AST_INNER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_end && !branch_taken && end_inner && count_inner > CW'(1) && !setup_valid)
      |=> (count_inner == $past(count_inner) - CW'(1)) && $stable(count_outer)); // R7
endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.CW(CW)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .setup_valid  (setup_valid),
   .pkt_end      (pkt_end),
   .end_inner    (end_inner),
   .end_outer    (end_outer),
   .branch_taken (branch_taken),
   .redir_valid  (redir_valid),
   .count_inner  (count_inner),
   .count_outer  (count_outer)
);

// File: tb/test_hwloop_ctrl.sv
`timescale 1ns/1ps
module test_hwloop_ctrl;
   localparam int AW = 32;
   localparam int CW = 16;
   localparam logic [AW-1:0] AMASK = ~AW'(3);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic setup_valid = 1'b0, setup_level = 1'b0;
   logic [AW-1:0] setup_offset = '0, pc_in = '0;
   logic [CW-1:0] setup_count = '0;
   logic pkt_end = 1'b0, end_inner = 1'b0, end_outer = 1'b0, branch_taken = 1'b0;
   logic redir_valid;
   logic [AW-1:0] redir_target;
   logic [CW-1:0] count_inner, count_outer;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [AW-1:0] m_start [2];
   logic [CW-1:0] m_cnt [2];
   string tag;

   always #4 clk = ~clk;

   hwloop_ctrl i_hwloop_ctrl (.*);

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic string pick_tag(input bit sv, input bit pe, input bit f0,
                                      input bit f1, input bit br);
      if (sv && pe) return "R11";
      if (sv) return "R2";
      if (!pe) return "R10";
      if (br) return "R9";
      if (f0 && f1) return (m_cnt[0] > 1) ? "R7" : "R8";
      if (f0) return (m_cnt[0] > 1) ? "R3" : (m_cnt[0] == 1) ? "R4" : "R5";
      if (f1) return (m_cnt[1] == 0) ? "R5" : "R6";
      return "R10";
   endfunction

   // one packet cycle: drive at negedge, check comb redirect, advance model, check counts
   task automatic step(input bit sv, input bit lvl, input logic [AW-1:0] off,
                       input logic [CW-1:0] cnt, input logic [AW-1:0] pc,
                       input bit pe, input bit f0, input bit f1, input bit br);
      bit e_rv, loop0, hit0, hit1, loop1;
      logic [AW-1:0] e_tgt;
      @(negedge clk);
      setup_valid = sv; setup_level = lvl; setup_offset = off; setup_count = cnt;
      pc_in = pc; pkt_end = pe; end_inner = f0; end_outer = f1; branch_taken = br;
      tag = pick_tag(sv, pe, f0, f1, br);
      hit0  = pe && !br && f0;
      loop0 = hit0 && m_cnt[0] > 1;
      hit1  = pe && !br && f1 && !loop0;
      loop1 = hit1 && m_cnt[1] > 1;
      e_rv  = loop0 || loop1;
      e_tgt = loop0 ? m_start[0] : m_start[1];
      #1;
      check(tag, 64'(redir_valid), 64'(e_rv));
      if (e_rv) check(tag, 64'(redir_target), 64'(e_tgt));
      if (hit0 && m_cnt[0] != 0) m_cnt[0] = m_cnt[0] - 1'b1;
      if (hit1 && m_cnt[1] != 0) m_cnt[1] = m_cnt[1] - 1'b1;
      if (sv) begin
         m_start[lvl] = (pc + off) & AMASK;
         m_cnt[lvl]   = cnt;
      end
      @(posedge clk);
      #1;
      check(tag, 64'(count_inner), 64'(m_cnt[0]));
      check(tag, 64'(count_outer), 64'(m_cnt[1]));
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      m_start[0] = '0; m_start[1] = '0; m_cnt[0] = '0; m_cnt[1] = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R1", 64'(count_inner), 64'(0));
      check("R1", 64'(count_outer), 64'(0));
      check("R1", 64'(redir_valid), 64'(0));
      @(negedge clk);
      rst_n = 1'b1;
      // R2: setups, inner start 0x123 aligns to 0x120
      step(1, 0, 32'h23, 3, 32'h100, 0, 0, 0, 0);
      step(1, 1, 32'h10, 2, 32'h1000, 0, 0, 0, 0);
      step(0, 0, 0, 0, 32'h140, 1, 1, 0, 0);   // R3
      step(0, 0, 0, 0, 32'h140, 1, 1, 1, 0);   // R7
      step(0, 0, 0, 0, 32'h140, 1, 1, 1, 0);   // R8 outer loops to 0x1010
      step(0, 0, 0, 0, 32'h140, 1, 1, 0, 0);   // R5 inner at zero
      step(0, 0, 0, 0, 32'h140, 1, 0, 1, 1);   // R9 branch wins
      step(0, 0, 0, 0, 32'h140, 0, 1, 1, 0);   // R10 no strobe
      step(0, 0, 0, 0, 32'h140, 1, 0, 1, 0);   // R6 outer finishes
      step(1, 0, 32'h4, 1, 32'h200, 0, 0, 0, 0);
      step(0, 0, 0, 0, 32'h240, 1, 1, 0, 0);   // R4
      step(1, 0, 32'h8, 4, 32'h300, 0, 0, 0, 0);
      step(1, 0, 32'h0, 2, 32'h400, 1, 1, 0, 0); // R11 setup beats decrement
      for (int i = 0; i < 4000; i++) begin
         step(($urandom % 8) == 0, $urandom % 2, $urandom, CW'($urandom % 5),
              $urandom, $urandom % 2, $urandom % 2, $urandom % 2, ($urandom % 8) == 0);
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule